// File: doc/BRIEF.md
# CAN Controller Interrupt Unit

This block turns the status of a CAN controller core into sticky interrupt flags and four interrupt request lines: transmit, receive, wake-up and error. It watches three transmit buffers, the receive FIFO's hand-off of frames into the foreground buffer, a FIFO overrun pulse, the two error counters, and bus activity while the controller sleeps. Each flag has its own local enable. Each request line is the registered OR of its enabled flags.

Software clears a flag by writing a one to its bit in a strobe vector. When a set event arrives in the same cycle as the clear, the set wins. The transmit-empty flags cannot be cleared this way: they follow the buffers' scheduled state. The receive flag re-arms on its own when a cleared message is followed by another one queued in the FIFO. The block also encodes each error counter into a two-bit bus state. Whenever either state changes, the block raises a status-change flag.

Top module: `can_irq_unit`

## Requirements
- R1: Each request line (`irq_tx`, `irq_rx`, `irq_wake`, `irq_err`) asserts one cycle after a flag it covers is set with its enable bit at 1. A flag whose enable is 0 never drives its line.
- R2: `txe_flags[i]` follows `tx_buf_empty[i]` (1 = buffer not scheduled) one cycle later, and no write to `flag_clr` changes it. `irq_tx` asserts when any buffer with its enable set is empty.
- R3: A one-cycle pulse on `rx_eof_shift` sets `rxf_flag` at the next edge. Writing 1 to `flag_clr[0]` clears it.
- R4: If `rxf_flag` is cleared while `rx_fifo_pending` is 1, `rxf_flag` reads 0 for one cycle and is then set again without a new `rx_eof_shift`.
- R5: A set event in the same cycle as a clear of that flag leaves the flag set. The clear bits are: bit 0 receive, bit 1 wake-up, bit 2 overrun, bit 3 status change. Writing 1 to one bit leaves the other flags unchanged.
- R6: `wup_flag` sets only when `bus_activity`, `sleep_mode` and `wake_det_en` are all 1 in the same cycle.
- R7: A pulse on `rx_overrun` sets `ovr_flag`. `irq_err` covers `ovr_flag` and `csc_flag` under their own enables.
- R8: `tx_state` encodes the transmit counter one cycle after it changes: 00 for 0–95, 01 for 96–127, 10 for 128–255, 11 for 256 and above.
- R9: `rx_state` uses the same encoding without the bus-off code: 00 for 0–95, 01 for 96–127, 10 for 128 and above. It never reads 11.
- R10: `csc_flag` sets in the same cycle that either encoded state field changes, and not when a counter moves inside one range.
- R11: After reset all enables are 0, `txe_flags` are all 1, the other flags and all request lines are 0, and both state fields are 00.
- R12: A cycle with `ien_we` = 1 loads `ien_wdata` into the enables. The bit layout is: bits 2:0 transmit buffers 0–2, bit 3 receive, bit 4 wake-up, bit 5 overrun, bit 6 status change. `ien_q` shows the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_buf_empty | input | NUM_TXBUF | Per-buffer empty (not scheduled) status |
| rx_eof_shift | input | 1 | Pulse: frame finished and moved into foreground buffer |
| rx_fifo_pending | input | 1 | Another received frame waits behind the foreground buffer |
| rx_overrun | input | 1 | Pulse: receive FIFO overrun |
| tx_err_cnt | input | TEC_W | Transmit error counter |
| rx_err_cnt | input | REC_W | Receive error counter |
| sleep_mode | input | 1 | Controller in internal sleep |
| wake_det_en | input | 1 | Wake-up detection enabled by control register |
| bus_activity | input | 1 | Bus activity detected |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | NUM_TXBUF+4 | Enable register write data |
| flag_clr | input | 4 | Write-one-to-clear strobes |
| txe_flags | output | NUM_TXBUF | Transmit-empty flags |
| rxf_flag | output | 1 | Receive-full flag |
| wup_flag | output | 1 | Wake-up flag |
| ovr_flag | output | 1 | Overrun flag |
| csc_flag | output | 1 | Bus-state change flag |
| tx_state | output | 2 | Encoded transmitter bus state |
| rx_state | output | 2 | Encoded receiver bus state |
| ien_q | output | NUM_TXBUF+4 | Current enables |
| irq_tx | output | 1 | Transmit request |
| irq_rx | output | 1 | Receive request |
| irq_wake | output | 1 | Wake-up request |
| irq_err | output | 1 | Error request |

## Verification
The block has two levels of registers. Flags, state fields and transmit mirrors change at the first clock edge after a stimulus, and request lines follow one edge later. The bench drives on falling edges and samples flags and states at the next falling edge. It samples request lines one falling edge after that. The re-arm check samples twice: a 0 one edge after the clear and a 1 the edge after.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  typedef enum logic [1:0] {
    BUS_OK      = 2'b00,
    BUS_WARN    = 2'b01,
    BUS_PASSIVE = 2'b10,
    BUS_OFF     = 2'b11
  } bus_state_e;

  // bit positions in the write-one-to-clear strobe vector
  localparam int CLR_RXF = 0;
  localparam int CLR_WUP = 1;
  localparam int CLR_OVR = 2;
  localparam int CLR_CSC = 3;
  localparam int CLR_W   = 4;

endpackage

// File: rtl/can_irq_state_enc.sv
module can_irq_state_enc
  import can_irq_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_LIM   = 96,
  parameter int PASV_LIM   = 128,
  parameter int OFF_LIM    = 256,
  parameter bit HAS_BUSOFF = 1'b1
) (
  input  logic [CNT_W-1:0] cnt,
  output bus_state_e       state
);

  logic [31:0] cnt32;
  assign cnt32 = 32'(cnt);

  generate
    if (HAS_BUSOFF) begin : g_with_off
      always_comb begin
        if (cnt32 >= 32'(OFF_LIM))       state = BUS_OFF;
        else if (cnt32 >= 32'(PASV_LIM)) state = BUS_PASSIVE;
        else if (cnt32 >= 32'(WARN_LIM)) state = BUS_WARN;
        else                             state = BUS_OK;
      end
    end else begin : g_no_off
      always_comb begin
        if (cnt32 >= 32'(PASV_LIM))      state = BUS_PASSIVE;
        else if (cnt32 >= 32'(WARN_LIM)) state = BUS_WARN;
        else                             state = BUS_OK;
      end
    end
  endgenerate

endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);

  // set beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (set_ev) q <= 1'b1;
    else if (clr_ev) q <= 1'b0;
  end

endmodule

// File: rtl/can_irq_req.sv
module can_irq_req #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & enables);
  end

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int NUM_TXBUF = 3,
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASV_LIM  = 128,
  parameter int OFF_LIM   = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TXBUF-1:0] tx_buf_empty,
  input  logic                 rx_eof_shift,
  input  logic                 rx_fifo_pending,
  input  logic                 rx_overrun,
  input  logic [TEC_W-1:0]     tx_err_cnt,
  input  logic [REC_W-1:0]     rx_err_cnt,
  input  logic                 sleep_mode,
  input  logic                 wake_det_en,
  input  logic                 bus_activity,
  input  logic                 ien_we,
  input  logic [NUM_TXBUF+3:0] ien_wdata,
  input  logic [3:0]           flag_clr,
  output logic [NUM_TXBUF-1:0] txe_flags,
  output logic                 rxf_flag,
  output logic                 wup_flag,
  output logic                 ovr_flag,
  output logic                 csc_flag,
  output logic [1:0]           tx_state,
  output logic [1:0]           rx_state,
  output logic [NUM_TXBUF+3:0] ien_q,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_wake,
  output logic                 irq_err
);

  localparam int IEN_W    = NUM_TXBUF + 4;
  localparam int IDX_RX   = NUM_TXBUF;
  localparam int IDX_WAKE = NUM_TXBUF + 1;
  localparam int IDX_OVR  = NUM_TXBUF + 2;
  localparam int IDX_CSC  = NUM_TXBUF + 3;

  // ---------------- enable register ----------------
  logic [IEN_W-1:0] ien_r;
  always_ff @(posedge clk) begin
    if (rst)         ien_r <= '0;
    else if (ien_we) ien_r <= ien_wdata;
  end
  assign ien_q = ien_r;

  // ---------------- transmit-empty mirrors ----------------
  logic [NUM_TXBUF-1:0] txe_r;
  generate
    for (genvar b = 0; b < NUM_TXBUF; b++) begin : g_txe
      always_ff @(posedge clk) begin
        if (rst) txe_r[b] <= 1'b1;
        else     txe_r[b] <= tx_buf_empty[b];
      end
    end
  endgenerate
  assign txe_flags = txe_r;

  // ---------------- receive flag with FIFO re-arm ----------------
  logic rearm_r;
  logic rxf_q;
  always_ff @(posedge clk) begin
    if (rst) rearm_r <= 1'b0;
    else     rearm_r <= flag_clr[CLR_RXF] & rxf_q & rx_fifo_pending & ~rx_eof_shift;
  end

  can_irq_flag u_rxf (
    .clk    (clk),
    .rst    (rst),
    .set_ev (rx_eof_shift | rearm_r),
    .clr_ev (flag_clr[CLR_RXF]),
    .q      (rxf_q)
  );
  assign rxf_flag = rxf_q;

  // ---------------- wake-up flag ----------------
  logic wake_hit;
  assign wake_hit = bus_activity & sleep_mode & wake_det_en;

  can_irq_flag u_wup (
    .clk    (clk),
    .rst    (rst),
    .set_ev (wake_hit),
    .clr_ev (flag_clr[CLR_WUP]),
    .q      (wup_flag)
  );

  // ---------------- overrun flag ----------------
  can_irq_flag u_ovr (
    .clk    (clk),
    .rst    (rst),
    .set_ev (rx_overrun),
    .clr_ev (flag_clr[CLR_OVR]),
    .q      (ovr_flag)
  );

  // ---------------- bus state encoding ----------------
  bus_state_e tx_nxt, rx_nxt, tx_cur, rx_cur;

  can_irq_state_enc #(
    .CNT_W(TEC_W), .WARN_LIM(WARN_LIM), .PASV_LIM(PASV_LIM),
    .OFF_LIM(OFF_LIM), .HAS_BUSOFF(1'b1)
  ) u_tx_enc (
    .cnt   (tx_err_cnt),
    .state (tx_nxt)
  );

  can_irq_state_enc #(
    .CNT_W(REC_W), .WARN_LIM(WARN_LIM), .PASV_LIM(PASV_LIM),
    .OFF_LIM(OFF_LIM), .HAS_BUSOFF(1'b0)
  ) u_rx_enc (
    .cnt   (rx_err_cnt),
    .state (rx_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cur <= BUS_OK;
      rx_cur <= BUS_OK;
    end else begin
      tx_cur <= tx_nxt;
      rx_cur <= rx_nxt;
    end
  end
  assign tx_state = tx_cur;
  assign rx_state = rx_cur;

  logic state_moved;
  assign state_moved = (tx_nxt != tx_cur) | (rx_nxt != rx_cur);

  can_irq_flag u_csc (
    .clk    (clk),
    .rst    (rst),
    .set_ev (state_moved),
    .clr_ev (flag_clr[CLR_CSC]),
    .q      (csc_flag)
  );

  // ---------------- request lines ----------------
  can_irq_req #(.W(NUM_TXBUF)) u_req_tx (
    .clk(clk), .rst(rst), .flags(txe_r),
    .enables(ien_r[NUM_TXBUF-1:0]), .irq(irq_tx)
  );

  can_irq_req #(.W(1)) u_req_rx (
    .clk(clk), .rst(rst), .flags(rxf_q),
    .enables(ien_r[IDX_RX]), .irq(irq_rx)
  );

  can_irq_req #(.W(1)) u_req_wake (
    .clk(clk), .rst(rst), .flags(wup_flag),
    .enables(ien_r[IDX_WAKE]), .irq(irq_wake)
  );

  can_irq_req #(.W(2)) u_req_err (
    .clk(clk), .rst(rst), .flags({csc_flag, ovr_flag}),
    .enables({ien_r[IDX_CSC], ien_r[IDX_OVR]}), .irq(irq_err)
  );

endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk #(
  parameter int NUM_TXBUF = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TXBUF-1:0] tx_buf_empty,
  input logic                 rx_eof_shift,
  input logic                 rx_fifo_pending,
  input logic                 rx_overrun,
  input logic                 sleep_mode,
  input logic                 wake_det_en,
  input logic                 bus_activity,
  input logic [3:0]           flag_clr,
  input logic [NUM_TXBUF-1:0] txe_flags,
  input logic                 rxf_flag,
  input logic                 wup_flag,
  input logic                 ovr_flag,
  input logic                 csc_flag,
  input logic [1:0]           tx_state,
  input logic [1:0]           rx_state,
  input logic [NUM_TXBUF+3:0] ien_q,
  input logic                 irq_tx,
  input logic                 irq_rx
);

  a_r1_rx_masked: assert property (@(posedge clk) disable iff (rst)
    !(rxf_flag && ien_q[NUM_TXBUF]) |=> !irq_rx);

  a_r2_tx_request: assert property (@(posedge clk) disable iff (rst)
    (|(txe_flags & ien_q[NUM_TXBUF-1:0])) |=> irq_tx);

  a_r2_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (txe_flags == $past(tx_buf_empty)));

  a_r4_rearm: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[0] && rxf_flag && rx_fifo_pending && !rx_eof_shift) |=> ##1 rxf_flag);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && flag_clr[2]) |=> ovr_flag);

  a_r6_wake_in_sleep: assert property (@(posedge clk) disable iff (rst)
    $rose(wup_flag) |-> $past(sleep_mode && wake_det_en && bus_activity));

  a_r9_rx_no_busoff: assert property (@(posedge clk) disable iff (rst)
    rx_state != 2'b11);

  a_r10_change_flags: assert property (@(posedge clk) disable iff (rst)
    ((tx_state != $past(tx_state)) || (rx_state != $past(rx_state))) |-> csc_flag);

endmodule

bind can_irq_unit can_irq_unit_chk #(.NUM_TXBUF(NUM_TXBUF)) chk_i (
  .clk(clk), .rst(rst), .tx_buf_empty(tx_buf_empty), .rx_eof_shift(rx_eof_shift),
  .rx_fifo_pending(rx_fifo_pending), .rx_overrun(rx_overrun), .sleep_mode(sleep_mode),
  .wake_det_en(wake_det_en), .bus_activity(bus_activity), .flag_clr(flag_clr),
  .txe_flags(txe_flags), .rxf_flag(rxf_flag), .wup_flag(wup_flag), .ovr_flag(ovr_flag),
  .csc_flag(csc_flag), .tx_state(tx_state), .rx_state(rx_state), .ien_q(ien_q),
  .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/can_irq_unit_tb_top.sv
module can_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] tx_buf_empty = 3'b111;
  logic       rx_eof_shift = 1'b0, rx_fifo_pending = 1'b0, rx_overrun = 1'b0;
  logic [8:0] tx_err_cnt = '0;
  logic [7:0] rx_err_cnt = '0;
  logic       sleep_mode = 1'b0, wake_det_en = 1'b0, bus_activity = 1'b0;
  logic       ien_we = 1'b0;
  logic [6:0] ien_wdata = '0;
  logic [3:0] flag_clr = '0;
  logic [2:0] txe_flags;
  logic       rxf_flag, wup_flag, ovr_flag, csc_flag;
  logic [1:0] tx_state, rx_state;
  logic [6:0] ien_q;
  logic       irq_tx, irq_rx, irq_wake, irq_err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_irq_unit dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nedge(); @(negedge clk); endtask

  task automatic write_ien(input logic [6:0] v);
    ien_we = 1'b1; ien_wdata = v; nedge(); ien_we = 1'b0;
  endtask

  task automatic pulse_clr(input logic [3:0] v);
    flag_clr = v; nedge(); flag_clr = '0;
  endtask

  // {tec[8:0], rec[7:0], tx_state, rx_state}
  localparam logic [20:0] VEC [10] = '{
    {9'd0,   8'd0,   2'b00, 2'b00},
    {9'd95,  8'd95,  2'b00, 2'b00},
    {9'd96,  8'd0,   2'b01, 2'b00},
    {9'd96,  8'd96,  2'b01, 2'b01},
    {9'd127, 8'd127, 2'b01, 2'b01},
    {9'd128, 8'd128, 2'b10, 2'b10},
    {9'd255, 8'd255, 2'b10, 2'b10},
    {9'd256, 8'd255, 2'b11, 2'b10},
    {9'd511, 8'd40,  2'b11, 2'b00},
    {9'd10,  8'd40,  2'b00, 2'b00}
  };

  initial begin
    logic [1:0] ptx, prx;
    repeat (3) nedge();
    rst = 1'b0;
    nedge();
    // R11 reset state
    chk("R11 txe", txe_flags, 7);
    chk("R11 flags", {rxf_flag, wup_flag, ovr_flag, csc_flag}, 0);
    chk("R11 ien", ien_q, 0);
    chk("R11 states", {tx_state, rx_state}, 0);
    chk("R11 irqs", {irq_tx, irq_rx, irq_wake, irq_err}, 0);

    // R8 R9 R10 table walk
    ptx = 2'b00; prx = 2'b00;
    for (int i = 0; i < 10; i++) begin
      tx_err_cnt = VEC[i][20:12];
      rx_err_cnt = VEC[i][11:4];
      nedge();
      chk("R8 tx_state", tx_state, VEC[i][3:2]);
      chk("R9 rx_state", rx_state, VEC[i][1:0]);
      chk("R10 csc", csc_flag, ((VEC[i][3:2] != ptx) || (VEC[i][1:0] != prx)) ? 1 : 0);
      ptx = VEC[i][3:2]; prx = VEC[i][1:0];
      pulse_clr(4'b1000);
    end
    chk("R10 cleared", csc_flag, 0);

    // R12 enable write, R2 transmit request
    write_ien(7'b0000010);
    chk("R12 ien", ien_q, 2);
    tx_buf_empty = 3'b101;
    nedge();
    chk("R2 mirror", txe_flags, 5);
    nedge();
    chk("R2 irq_tx off", irq_tx, 0);
    pulse_clr(4'b1111);
    chk("R2 no clear", txe_flags, 5);
    tx_buf_empty = 3'b010;
    nedge(); nedge();
    chk("R2 irq_tx on", irq_tx, 1);
    tx_buf_empty = 3'b111;

    // R3 receive flag, R1 masked then enabled
    rx_eof_shift = 1'b1; nedge(); rx_eof_shift = 1'b0;
    chk("R3 rxf set", rxf_flag, 1);
    nedge();
    chk("R1 irq_rx masked", irq_rx, 0);
    write_ien(7'b0001000);
    nedge();
    chk("R1 irq_rx", irq_rx, 1);

    // R4 re-arm from FIFO
    rx_fifo_pending = 1'b1;
    pulse_clr(4'b0001);
    chk("R4 rxf gap", rxf_flag, 0);
    nedge();
    chk("R4 rxf rearm", rxf_flag, 1);
    rx_fifo_pending = 1'b0;
    pulse_clr(4'b0001);
    chk("R3 rxf clear", rxf_flag, 0);
    nedge();
    chk("R4 no rearm", rxf_flag, 0);

    // R5 set beats clear, selective clear
    rx_eof_shift = 1'b1; flag_clr = 4'b0001; nedge();
    rx_eof_shift = 1'b0; flag_clr = 4'b0000;
    chk("R5 set wins", rxf_flag, 1);
    rx_overrun = 1'b1; nedge(); rx_overrun = 1'b0;
    pulse_clr(4'b0100);
    chk("R5 ovr cleared", ovr_flag, 0);
    chk("R5 rxf kept", rxf_flag, 1);

    // R6 wake-up qualification
    bus_activity = 1'b1; nedge();
    chk("R6 awake", wup_flag, 0);
    sleep_mode = 1'b1; nedge();
    chk("R6 detect off", wup_flag, 0);
    wake_det_en = 1'b1; nedge(); bus_activity = 1'b0;
    chk("R6 wake set", wup_flag, 1);
    write_ien(7'b0010000);
    nedge();
    chk("R1 irq_wake", irq_wake, 1);
    sleep_mode = 1'b0;

    // R7 overrun and error request
    rx_overrun = 1'b1; nedge(); rx_overrun = 1'b0;
    chk("R7 ovr set", ovr_flag, 1);
    nedge();
    chk("R7 irq_err masked", irq_err, 0);
    write_ien(7'b0100000);
    nedge();
    chk("R7 irq_err", irq_err, 1);
    pulse_clr(4'b0100);
    nedge();
    chk("R7 irq_err drop", irq_err, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule